// File: doc/BRIEF.md
# Bit-Serial Adder

The block adds two unsigned operands of `WIDTH` bits with a single full-adder cell and one carry flip-flop. It works one bit per clock cycle, least significant bit first. The two operands and the result each sit in a shift register that moves right by one position every working cycle. The sum bit of each cycle enters the top end of the result register. The carry leaving the cell is held in the carry flip-flop for the next bit.

A small controller sequences the work. A one-cycle `start` pulse while the block is idle loads both operands, clears the result and clears the carry flip-flop. The controller then counts `WIDTH` shift cycles and raises `done`. `done` stays high, and the result and the final carry stay frozen, until the next `start`. The block trades adder area for latency: one cell serves every bit position, so an addition costs `WIDTH` cycles instead of one.

Top module: `serial_adder`

## Requirements
- R1: After reset, `done` is 0, `result` is 0 and `carry_out` is 0.
- R2: When `start` is sampled high by a rising edge while the block is idle or finished, `done` goes high exactly `WIDTH` rising edges after that edge, and not before.
- R3: When `done` is high, `result` equals `(op_a + op_b) mod 2^WIDTH` and `carry_out` equals bit `WIDTH` of the full sum `op_a + op_b`, where `op_a` and `op_b` are the values captured at the start edge.
- R4: Each new addition begins with the carry cleared: `carry_out` reads 0 from the edge that accepts `start` until `done` rises, and a previous carry never leaks into the next sum.
- R5: While `done` is high and `start` is low, `done` stays high and `result` and `carry_out` stay unchanged.
- R6: While an addition is running, pulses on `start` and changes on `op_a` and `op_b` are ignored; the result and the completion time are those of the operands captured at the start edge.
- R7: A `start` pulse while `done` is high begins a new addition, and `done` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an addition; sampled only when not running |
| op_a | input | WIDTH | First operand, captured at the start edge |
| op_b | input | WIDTH | Second operand, captured at the start edge |
| done | output | 1 | High once the last bit has been added, until the next start |
| result | output | WIDTH | Sum modulo 2^WIDTH, valid while done is high |
| carry_out | output | 1 | Carry out of the top bit, valid while done is high |

## Verification
The bench aims at carry chains that cross every bit, such as all ones plus one and all ones plus all ones. A design that dropped the carry flip-flop, or delayed it by a cycle, would give a wrong low bit or lose the final carry in those cases. It checks an addition with a carry out followed directly by zero plus zero, which exposes a carry that is not cleared at start. It pulses `start` and changes the operands in the middle of a run, so a controller that restarts or re-samples its operands would finish late or with the wrong sum. It also checks the exact cycle on which `done` rises, which catches a counter off by one in either direction.

// File: rtl/serial_adder_pkg.sv
package serial_adder_pkg;

    typedef enum logic [1:0] {
        SA_IDLE = 2'd0,
        SA_RUN  = 2'd1,
        SA_DONE = 2'd2
    } sa_state_e;

endpackage

// File: rtl/sa_full_adder.sv
module sa_full_adder (
    input  logic x,
    input  logic y,
    input  logic cin,
    output logic sum,
    output logic cout
);

    logic prop;

    always_comb begin
        prop = x ^ y;
        sum  = prop ^ cin;
        cout = (x & y) | (prop & cin);
    end

endmodule

// File: rtl/sa_shift_reg.sv
module sa_shift_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q,
    output logic             lsb
);

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } shreg_t;

    shreg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.bits = load_val;
        end else if (shift) begin
            r_d.bits = {ser_in, r_q.bits[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign q   = r_q.bits;
    assign lsb = r_q.bits[0];

    // R6
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(r_q.bits));

endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl
    import serial_adder_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic shift,
    output logic last,
    output logic done
);

    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIDTH - 1);

    typedef struct packed {
        sa_state_e        state;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d   = c_q;
        load  = 1'b0;
        shift = 1'b0;
        last  = 1'b0;
        unique case (c_q.state)
            SA_IDLE, SA_DONE: begin
                if (start) begin
                    load      = 1'b1;
                    c_d.state = SA_RUN;
                    c_d.cnt   = '0;
                end
            end
            SA_RUN: begin
                shift = 1'b1;
                if (c_q.cnt == CNT_LAST) begin
                    last      = 1'b1;
                    c_d.state = SA_DONE;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
            default: begin
                c_d.state = SA_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{state: SA_IDLE, cnt: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign done = (c_q.state == SA_DONE);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.cnt <= CNT_LAST);

    // R6
    run_not_restarted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == SA_RUN && c_q.cnt != CNT_LAST) |=> (c_q.state == SA_RUN && c_q.cnt == $past(c_q.cnt) + 1'b1));

    // R7
    restart_from_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == SA_DONE && start) |=> (c_q.state == SA_RUN && c_q.cnt == '0));

endmodule

// File: rtl/serial_adder.sv
module serial_adder
    import serial_adder_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             done,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);

    localparam int N_OPS = 2;

    typedef struct packed {
        logic carry;
        logic cout;
    } cy_t;

    logic                         load;
    logic                         shift;
    logic                         last;
    logic [N_OPS-1:0][WIDTH-1:0]  op_in;
    logic [N_OPS-1:0][WIDTH-1:0]  op_q;
    logic [N_OPS-1:0]             op_lsb;
    logic                         fa_sum;
    logic                         fa_cout;
    logic                         r_lsb;
    cy_t                          cy_d, cy_q;

    assign op_in[0] = op_a;
    assign op_in[1] = op_b;

    sa_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .shift (shift),
        .last  (last),
        .done  (done)
    );

    for (genvar g = 0; g < N_OPS; g++) begin : g_opreg
        sa_shift_reg #(.WIDTH(WIDTH)) u_opreg (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .load_val (op_in[g]),
            .shift    (shift),
            .ser_in   (1'b0),
            .q        (op_q[g]),
            .lsb      (op_lsb[g])
        );
    end

    sa_full_adder u_fa (
        .x    (op_lsb[0]),
        .y    (op_lsb[1]),
        .cin  (cy_q.carry),
        .sum  (fa_sum),
        .cout (fa_cout)
    );

    sa_shift_reg #(.WIDTH(WIDTH)) u_resreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val ('0),
        .shift    (shift),
        .ser_in   (fa_sum),
        .q        (result),
        .lsb      (r_lsb)
    );

    always_comb begin
        cy_d = cy_q;
        if (load) begin
            cy_d.carry = 1'b0;
            cy_d.cout  = 1'b0;
        end else if (shift) begin
            cy_d.carry = fa_cout;
            if (last) begin
                cy_d.cout = fa_cout;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cy_q <= '0;
        end else begin
            cy_q <= cy_d;
        end
    end

    assign carry_out = cy_q.cout;

    // R4
    carry_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cy_q.carry == 1'b0 && carry_out == 1'b0));

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R5
    result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(result) && $stable(carry_out)));

    // R7
    done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done);

    // R4
    cout_zero_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !last) |=> (carry_out == 1'b0));

endmodule

// File: tb/serial_adder_tb.sv
module serial_adder_tb;

    localparam int W = 8;

    logic         clk;
    logic         rst_n;
    logic         start;
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic         done;
    logic [W-1:0] result;
    logic         carry_out;

    int n_tests;
    int n_fail;

    serial_adder #(.WIDTH(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_a      (op_a),
        .op_b      (op_b),
        .done      (done),
        .result    (result),
        .carry_out (carry_out)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic logic [W:0] ref_sum(input logic [W-1:0] a, input logic [W-1:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // disturb: pulse start and change operands mid-run (R6)
    task automatic do_add(input logic [W-1:0] a, input logic [W-1:0] b, input bit disturb);
        logic [W:0] exp;
        exp = ref_sum(a, b);
        @(negedge clk);
        op_a  = a;
        op_b  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R7 / R4: after accepting start, not done and carry cleared
        check(done == 1'b0, "R7 done low after start", done, 0);
        check(carry_out == 1'b0, "R4 carry_out cleared at start", carry_out, 0);
        for (int i = 1; i < W; i++) begin
            @(negedge clk);
            if (disturb && i == 2) begin
                start = 1'b1;
                op_a  = ~a;
                op_b  = b ^ 8'h5a;
            end else if (disturb && i == 3) begin
                start = 1'b0;
            end
        end
        // R2: one edge before completion
        check(done == 1'b0, "R2 done not early", done, 0);
        @(negedge clk);
        check(done == 1'b1, "R2 done at WIDTH edges", done, 1);
        // R3 / R6
        check(result == exp[W-1:0], disturb ? "R6 result under disturb" : "R3 result", result, exp[W-1:0]);
        check(carry_out == exp[W], disturb ? "R6 carry under disturb" : "R3 carry_out", carry_out, exp[W]);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] held_r;
        logic         held_c;
        logic [W:0]   e;
        void'($urandom(32'd1234));
        n_tests = 0;
        n_fail  = 0;
        rst_n = 1'b0;
        start = 1'b0;
        op_a  = '0;
        op_b  = '0;
        repeat (3) @(negedge clk);
        // R1
        check(done == 1'b0, "R1 reset done", done, 0);
        check(result == '0, "R1 reset result", result, 0);
        check(carry_out == 1'b0, "R1 reset carry_out", carry_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 directed carry chains
        do_add(8'hff, 8'h01, 1'b0);
        do_add(8'hff, 8'hff, 1'b0);
        // R4: zero plus zero right after a carry out
        do_add(8'h00, 8'h00, 1'b0);
        do_add(8'h80, 8'h80, 1'b0);
        do_add(8'h55, 8'haa, 1'b0);
        do_add(8'h7f, 8'h01, 1'b0);

        // R5: hold while done with no start
        held_r = result;
        held_c = carry_out;
        repeat (5) @(negedge clk);
        check(done == 1'b1, "R5 done held", done, 1);
        check(result == held_r, "R5 result held", result, held_r);
        check(carry_out == held_c, "R5 carry_out held", carry_out, held_c);

        // R6: disturbance during run
        do_add(8'hc3, 8'h5e, 1'b1);
        do_add(8'hff, 8'h01, 1'b1);

        // R3 constrained random
        for (int k = 0; k < 40; k++) begin
            do_add(W'($urandom), W'($urandom), 1'b0);
        end
        for (int k = 0; k < 10; k++) begin
            logic [W-1:0] ra;
            ra = W'($urandom);
            do_add(ra, ~ra + W'($urandom_range(0, 2)), 1'b0);
        end

        // R7: back-to-back restart from done, then R5 stability
        e = ref_sum(8'h12, 8'h34);
        do_add(8'h12, 8'h34, 1'b0);
        @(negedge clk);
        check(result == e[W-1:0], "R5 result after extra cycle", result, e[W-1:0]);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule